// File: doc/BRIEF.md
# Periodic Interval Timer

This peripheral produces a steady system tick. The input clock passes through a fixed divide-by-16 prescaler. Each prescaled tick advances a 20-bit interval counter. The interval counter runs from zero up to a programmed period value and then returns to zero. Each return to zero is a wrap. It raises a sticky period flag and adds one to a 12-bit elapsed-period counter. While the interrupt enable is set, the interrupt output follows the flag.

Software reaches the block over a single-cycle, word-wide register bus. The bus has no wait states and no back-pressure. A write is accepted in the cycle it is presented. Read data is combinational from the current state. A side effect of a read takes place at the clock edge that ends the access.

Two registers return the same counter snapshot:
- The acknowledge register also clears the flag and the elapsed-period count. This lets an interrupt handler learn how many periods it missed.
- The image register has no side effect, so it can be polled at any time.

Clearing the enable does not stop the interval counter at once. The counter keeps running until it next reaches zero, and then holds there. Software polls the interval count for zero to know that the timer has stopped.

Top module: `pit_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: The control register is at byte offset 0x0. It holds the period value in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25. Every other bit reads back as zero.
- R3: After the run enable is written, the interval count first increments 16 clocks after the write edge, and then once every 16 clocks. After it reaches the period value P, it returns to 0, so one period lasts (P+1)*16 clocks.
- R4: Each wrap sets the period flag and adds one to the 12-bit elapsed-period count, modulo 4096. The period flag reads as bit 0 of the status register at offset 0x4; the other status bits read zero.
- R5: The acknowledge register (offset 0x8) and the image register (offset 0xC) both return the elapsed-period count in bits 31:20 and the interval count in bits 19:0.
- R6: A read of offset 0x8 clears the period flag and the elapsed-period count at the end of the access. A read of offset 0xC changes nothing.
- R7: If a read of offset 0x8 and a wrap fall in the same cycle, the elapsed-period count becomes 1 and the flag stays set.
- R8: `irq` is high exactly while the period flag and the interrupt enable are both set. Clearing only the interrupt enable leaves counting and flag setting unchanged.
- R9: After the run enable is cleared, the interval counter keeps counting until it wraps to 0, and then holds at 0. The prescaler is held at zero while the timer is stopped, so a new enable again gives its first tick 16 clocks after the write.
- R10: Writes to offsets 0x4, 0x8 and 0xC are ignored. They change neither the counters, the flag nor the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Period interrupt, level |

## Verification
The main counting path is swept with small periods of 0, 1, 2, 3 and 6, reading the image register in every cycle of several whole periods.
- Period 0 wraps on every tick, which tells the compare-and-wrap apart from the plain increment.
- Larger periods expose any off-by-one in the prescaler or in the wrap point.

Alternating the interrupt enable across the sweep separates the flag from the interrupt output.

Directed patterns cover the remaining behaviour:
- An acknowledge read placed exactly on a wrap edge, which separates the clear-and-count priority from a plain clear.
- A disable issued mid-period, which checks that the counter drains to zero and that the prescaler restarts from zero.
- A 4096-period run, which checks the modulo wrap of the elapsed-period count.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned BUS_W = 32;

  // register select, from byte address bits 3:2
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_ACK   = 2'd2,
    SEL_IMAGE = 2'd3
  } pit_reg_e;

  localparam int unsigned RUN_BIT = 24;
  localparam int unsigned IEN_BIT = 25;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  assign tick = run && (&div_q);
endmodule

// File: rtl/pit_interval.sv
module pit_interval #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             wrap
);
  logic [CNT_W-1:0] count_q;

  // keep going after disable until the count is back at zero
  assign running = enable || (count_q != '0);
  assign wrap    = tick && (count_q == period);

  always_ff @(posedge clk) begin
    if (!rst_n)    count_q <= '0;
    else if (wrap) count_q <= '0;
    else if (tick) count_q <= count_q + 1'b1;
  end

  assign count = count_q;
endmodule

// File: rtl/pit_elapsed.sv
module pit_elapsed #(
  parameter int unsigned OVF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             ack,
  output logic [OVF_W-1:0] periods,
  output logic             flag
);
  localparam logic [OVF_W-1:0] ONE = {{(OVF_W-1){1'b0}}, 1'b1};

  logic [OVF_W-1:0] periods_q;
  logic             flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periods_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      unique case ({ack, wrap})
        2'b11:   begin periods_q <= ONE;             flag_q <= 1'b1; end
        2'b10:   begin periods_q <= '0;              flag_q <= 1'b0; end
        2'b01:   begin periods_q <= periods_q + ONE; flag_q <= 1'b1; end
        default: ;
      endcase
    end
  end

  assign periods = periods_q;
  assign flag    = flag_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int unsigned DIV_LOG2 = 4,
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned OVF_W    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  import pit_pkg::*;

  localparam int unsigned SNAP_W = CNT_W + OVF_W;
  localparam logic [31:0] CTRL_MASK =
    (32'd1 << RUN_BIT) | (32'd1 << IEN_BIT) | ((32'd1 << CNT_W) - 32'd1);

  pit_reg_e         reg_sel;
  logic             wr_ctrl;
  logic             rd_ack;
  logic [CNT_W-1:0] period_q;
  logic             en_q;
  logic             ien_q;
  logic             tick;
  logic             running;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [OVF_W-1:0] ovf_q;
  logic             flag_q;
  logic             unused_bits;

  assign reg_sel = pit_reg_e'(bus_addr[3:2]);
  assign wr_ctrl = bus_sel &&  bus_wr && (reg_sel == SEL_CTRL);
  assign rd_ack  = bus_sel && !bus_wr && (reg_sel == SEL_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      en_q     <= 1'b0;
      ien_q    <= 1'b0;
    end else if (wr_ctrl) begin
      period_q <= bus_wdata[CNT_W-1:0];
      en_q     <= bus_wdata[RUN_BIT];
      ien_q    <= bus_wdata[IEN_BIT];
    end
  end

  pit_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .tick  (tick)
  );

  pit_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (en_q),
    .tick    (tick),
    .period  (period_q),
    .count   (cnt_q),
    .running (running),
    .wrap    (wrap)
  );

  pit_elapsed #(.OVF_W(OVF_W)) u_ela (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap),
    .ack     (rd_ack),
    .periods (ovf_q),
    .flag    (flag_q)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL: begin
        bus_rdata[CNT_W-1:0] = period_q;
        bus_rdata[RUN_BIT]   = en_q;
        bus_rdata[IEN_BIT]   = ien_q;
      end
      SEL_STAT: bus_rdata[0] = flag_q;
      default:  bus_rdata[SNAP_W-1:0] = {ovf_q, cnt_q};
    endcase
  end

  assign irq = flag_q && ien_q;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata & ~CTRL_MASK};
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned OVF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrap,
  input logic             ack,
  input logic [CNT_W-1:0] cnt,
  input logic [OVF_W-1:0] ovf,
  input logic             flag,
  input logic             en,
  input logic             ien,
  input logic             irq
);
  localparam logic [CNT_W-1:0] C1 = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [OVF_W-1:0] O1 = {{(OVF_W-1){1'b0}}, 1'b1};

  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> cnt == $past(cnt) + C1);
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ack) |=> (ovf == $past(ovf) + O1) && flag);
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap) |=> (ovf == '0) && !flag);
  a_r7_ack_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wrap) |=> (ovf == O1) && flag);
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wrap) || $rose(ien)));
  a_r9_stays_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && cnt == '0) |=> (cnt == '0) && !$past(tick));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .wrap  (wrap),
  .ack   (rd_ack),
  .cnt   (cnt_q),
  .ovf   (ovf_q),
  .flag  (flag_q),
  .en    (en_q),
  .ien   (ien_q),
  .irq   (irq)
);

// File: tb/pit_timer_tb.sv
`timescale 1ns/1ps
module pit_timer_tb;
  localparam logic [31:0] RUN = 32'h0100_0000;
  localparam logic [31:0] IEN = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  always #10 clk = ~clk;

  pit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  int     n_pass = 0;
  int     n_tot = 0;
  longint ecnt = 0;
  longint base = 0;

  always @(posedge clk) ecnt <= ecnt + 1;

  task automatic summary;
    $display("  %0d/%0d checks passed", n_pass, n_tot);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tot++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tot++;
    if (act === exp) n_pass++;
    else $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  // side-effect-free look: select is dropped before any edge
  task automatic peek(logic [3:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic ack_read(output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = 4'h8;
    #1;
    d = rdata;
    @(posedge clk);
    #1;
    sel = 1'b0;
  endtask

  task automatic start(logic [31:0] mode);
    wr_reg(4'h0, mode);
    base = ecnt;
  endtask

  task automatic goto(longint t);
    @(negedge clk);
    while (ecnt - base < t) @(negedge clk);
  endtask

  function automatic logic [31:0] img_exp(longint n, int p);
    longint t;
    logic [11:0] o;
    logic [19:0] c;
    t = n / 16;
    o = 12'((t / (p + 1)) % 4096);
    c = 20'(t % (p + 1));
    return {o, c};
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] e;
    int periods[5] = '{0, 1, 2, 3, 6};

    // R1 reset state
    do_reset();
    peek(4'h0, d); check("R1", "ctrl after reset", d, 32'h0);
    peek(4'h4, d); check("R1", "status after reset", d, 32'h0);
    peek(4'h8, d); check("R1", "ack reg after reset", d, 32'h0);
    peek(4'hC, d); check("R1", "image after reset", d, 32'h0);
    check("R1", "irq after reset", {31'b0, irq}, 32'h0);

    // R2 field layout and read-back mask
    wr_reg(4'h0, 32'hFFFF_FFFF);
    peek(4'h0, d); check("R2", "ctrl readback", d, 32'h030F_FFFF);
    wr_reg(4'h0, 32'h0100_0005);
    peek(4'h0, d); check("R2", "ctrl readback 2", d, 32'h0100_0005);

    // R3 R4 R5 R8 sweep over small periods
    foreach (periods[i]) begin
      int p;
      logic [31:0] ie;
      p = periods[i];
      ie = (i % 2 == 1) ? IEN : 32'h0;
      do_reset();
      start(32'(p) | RUN | ie);
      for (int n = 1; n <= 16 * (p + 1) * 3 + 24; n++) begin
        goto(n);
        e = img_exp(n, p);
        peek(4'hC, d); check("R3", "image sweep", d, e);
        peek(4'h4, d); check("R4", "status sweep", d, {31'b0, e[31:20] != 12'd0});
        check("R8", "irq sweep", {31'b0, irq},
              {31'b0, (e[31:20] != 12'd0) && (ie != 32'h0)});
      end
    end

    // R5 R6 R7 R8 acknowledge behaviour, period 0
    do_reset();
    start(RUN | IEN);
    goto(40);
    peek(4'hC, d); check("R5", "image before ack", d, {12'd2, 20'd0});
    ack_read(d);   check("R5", "ack reg returns snapshot", d, {12'd2, 20'd0});
    goto(41);
    peek(4'hC, d); check("R6", "count cleared by ack", d, 32'h0);
    peek(4'h4, d); check("R6", "flag cleared by ack", d, 32'h0);
    check("R6", "irq after ack", {31'b0, irq}, 32'h0);
    wr_reg(4'h0, RUN | IEN);
    base = base;
    goto(44);
    peek(4'hC, d); peek(4'hC, d); check("R6", "image read no side effect", d, 32'h0);
    goto(47);
    ack_read(d);
    goto(48);
    peek(4'hC, d); check("R7", "ack on wrap keeps one", d, {12'd1, 20'd0});
    peek(4'h4, d); check("R7", "ack on wrap keeps flag", d, 32'h1);
    check("R7", "irq after ack on wrap", {31'b0, irq}, 32'h1);
    wr_reg(4'h0, RUN);
    goto(51);
    check("R8", "irq masked", {31'b0, irq}, 32'h0);
    goto(64);
    peek(4'hC, d); check("R8", "counting with irq masked", d, {12'd2, 20'd0});
    peek(4'h4, d); check("R8", "flag with irq masked", d, 32'h1);
    wr_reg(4'h0, RUN | IEN);
    goto(66);
    check("R8", "irq re-enabled", {31'b0, irq}, 32'h1);

    // R9 drain to zero after disable, period 7
    do_reset();
    start(32'd7 | RUN);
    goto(50);
    wr_reg(4'h0, 32'd7);
    for (int n = 52; n <= 300; n++) begin
      goto(n);
      peek(4'hC, d);
      e = (n < 128) ? {12'd0, 20'((n / 16) % 8)} : {12'd1, 20'd0};
      check("R9", "drain after disable", d, e);
    end
    start(32'd7 | RUN);
    for (int m = 1; m <= 20; m++) begin
      goto(m);
      peek(4'hC, d);
      check("R9", "restart from zero prescale", d, {12'd1, 20'(m / 16)});
    end

    // R10 writes to read-only offsets
    do_reset();
    start(32'd3 | RUN);
    goto(20);
    wr_reg(4'h4, 32'hFFFF_FFFF);
    wr_reg(4'h8, 32'hFFFF_FFFF);
    wr_reg(4'hC, 32'hFFFF_FFFF);
    goto(100);
    peek(4'hC, d); check("R10", "counters after ignored writes", d, img_exp(100, 3));
    peek(4'h4, d); check("R10", "flag after ignored writes", d, 32'h1);
    peek(4'h0, d); check("R10", "ctrl after ignored writes", d, 32'd3 | RUN);

    // R4 modulo 4096, period 0
    do_reset();
    start(RUN);
    goto(16 * 4096);
    peek(4'hC, d); check("R4", "count wraps modulo 4096", d, 32'h0);
    peek(4'h4, d); check("R4", "flag after modulo wrap", d, 32'h1);
    goto(16 * 4097);
    peek(4'hC, d); check("R4", "count after modulo wrap", d, {12'd1, 20'd0});

    summary();
    $finish;
  end
endmodule